// File: doc/BRIEF.md
# Audio clock relationship monitor

This block sits beside the serial audio receiver of a digital-to-analog converter and watches three clocks: the system clock that drives it, and the bit clock and word clock of the incoming serial stream. The word and bit clocks pass through multi-flop synchronisers, and their rising edges are detected on the synchronised copies. Every word-clock period is measured in two ways: the number of system-clock cycles it spans, and the number of bit-clock rising edges it holds.

While unlocked, the block waits for consecutive periods whose measurements are plausible and agree with each other. It then learns the system-clock count as its reference, clears the error and pulses a resync flag. While locked, a drift of the system-clock count is reported at once, including when the word clock stops altogether. A wrong bit-clock count is reported only after it has persisted. For as long as the error stands, a force-zero output tells the data path to send all-zero samples. The accepted bit-clock ratios depend on a static mode input that selects multi-slot framing.

Top module: `acm_clock_monitor`

## Requirements
- R1: After reset, clk_err and force_zero are 1 and resync_done is 0.
- R2: The first rising word-clock edge after an error only starts a measurement. Once RESYNC_FRAMES (default 2) consecutive complete periods are valid, clk_err falls, and resync_done is 1 for exactly that cycle. A valid period passes R6 and R7, and all but the first of the run lie within TOL of the one before.
- R3: While locked, a period whose system-clock count differs from the learned reference by at most TOL (default 5) leaves clk_err at 0. A difference of TOL+1 or more sets clk_err.
- R4: force_zero equals clk_err in every cycle.
- R5: While locked, a bit-clock count that is not allowed sets clk_err only when it ends the BCK_LIMIT+1-th (default fifth) consecutive such period. An allowed period clears the run.
- R6: With tdm_mode=0 the allowed bit-clock counts per period are 32, 48 and 64. With tdm_mode=1 they are 128 and 256.
- R7: A period's system-clock count is acceptable only within TOL of one of 64, 128, 192, 256, 384, 512, 768, 1024, 1152, 1536, 2048 or 3072. Periods outside that set never lead to relock.
- R8: resync_done is never 1 except in the cycle in which clk_err falls.
- R9: The reference is reloaded at every relock, so a new rate that was locked to does not raise an error.
- R10: While locked, clk_err is set no later than ref+TOL+1 cycles after the last synchronised word-clock edge, even if no further edge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_in | input | 1 | Serial bit clock, asynchronous |
| lrck_in | input | 1 | Serial word clock, asynchronous, rising edge marks a frame |
| tdm_mode | input | 1 | Static: 1 selects multi-slot bit-clock ratios |
| clk_err | output | 1 | Clock relationship lost |
| force_zero | output | 1 | Data path must output all-zero samples |
| resync_done | output | 1 | One-cycle pulse when lock returns |

## Verification
The drift check and the persistent bit-clock check can both fire on the same word-clock edge. To provoke this, the bench sends four periods with a disallowed bit-clock count and then a fifth that is also six system-clock cycles short. At the edge that closes that fifth period, both error conditions are true at once. The scoreboard expects a single clean transition to error with no extra resync pulse, followed by an ordinary relock on the two periods that come next.

// File: rtl/acm_pkg.sv
package acm_pkg;

   localparam int NUM_SCK_RATIOS = 12;
   localparam int unsigned SCK_RATIOS [NUM_SCK_RATIOS] =
      '{64, 128, 192, 256, 384, 512, 768, 1024, 1152, 1536, 2048, 3072};

   // system-clock count acceptable within +/- tol of any supported ratio
   function automatic logic sck_ratio_ok(input int unsigned per, input int unsigned tol);
      logic ok;
      ok = 1'b0;
      for (int k = 0; k < NUM_SCK_RATIOS; k++) begin
         if ((per + tol >= SCK_RATIOS[k]) && (per <= SCK_RATIOS[k] + tol)) ok = 1'b1;
      end
      return ok;
   endfunction

   // bit-clock edges per word-clock period, set chosen by framing mode
   function automatic logic bck_ratio_ok(input int unsigned n, input logic multi_slot);
      if (multi_slot) return (n == 128) || (n == 256);
      return (n == 32) || (n == 48) || (n == 64);
   endfunction

   function automatic int unsigned abs_diff(input int unsigned a, input int unsigned b);
      return (a > b) ? (a - b) : (b - a);
   endfunction

endpackage

// File: rtl/acm_edge_sync.sv
module acm_edge_sync #(
   parameter int unsigned WIDTH  = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] rise
);

   if (STAGES < 2) begin : g_bad_stages
      $error("acm_edge_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic [STAGES-1:0] sh_q;
      logic              prev_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sh_q   <= '0;
            prev_q <= 1'b0;
         end else begin
            sh_q   <= {sh_q[STAGES-2:0], din[i]};
            prev_q <= sh_q[STAGES-1];
         end
      end

      assign rise[i] = sh_q[STAGES-1] & ~prev_q;
   end

endmodule

// File: rtl/acm_period_counter.sv
module acm_period_counter #(
   parameter int unsigned CNT_W  = 13,
   parameter int unsigned BCNT_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lr_rise,
   input  logic              bk_rise,
   input  logic              restart,
   output logic              per_done,
   output logic [CNT_W-1:0]  per_sck,
   output logic [BCNT_W-1:0] per_bck,
   output logic [CNT_W-1:0]  elapsed
);

   localparam logic [CNT_W-1:0]  CNT_MAX  = '1;
   localparam logic [BCNT_W-1:0] BCNT_MAX = '1;

   logic [CNT_W-1:0]  cnt_q;
   logic [BCNT_W-1:0] bcnt_q;
   logic              started_q;

   // cycles since the last word-clock edge, counting the present one
   assign elapsed  = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
   assign per_sck  = elapsed;
   assign per_bck  = bcnt_q;
   assign per_done = lr_rise & started_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         bcnt_q    <= '0;
         started_q <= 1'b0;
      end else if (lr_rise) begin
         // a bit-clock edge coinciding with the frame edge opens the new period
         cnt_q     <= '0;
         bcnt_q    <= bk_rise ? BCNT_W'(1) : '0;
         started_q <= 1'b1;
      end else if (restart) begin
         cnt_q     <= '0;
         bcnt_q    <= '0;
         started_q <= 1'b0;
      end else begin
         cnt_q <= elapsed;
         if (bk_rise && bcnt_q != BCNT_MAX) bcnt_q <= bcnt_q + 1'b1;
      end
   end

   // R10: an overrun abandons the period, so the next edge only starts a new one
   a_r10_restart_drops_period: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !per_done);

endmodule

// File: rtl/acm_lock_ctrl.sv
module acm_lock_ctrl
   import acm_pkg::*;
#(
   parameter int unsigned CNT_W         = 13,
   parameter int unsigned BCNT_W        = 10,
   parameter int unsigned TOL           = 5,
   parameter int unsigned RESYNC_FRAMES = 2,
   parameter int unsigned BCK_LIMIT     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lr_rise,
   input  logic              per_done,
   input  logic [CNT_W-1:0]  per_sck,
   input  logic [BCNT_W-1:0] per_bck,
   input  logic [CNT_W-1:0]  elapsed,
   input  logic              multi_slot,
   output logic              restart,
   output logic              clk_err,
   output logic              force_zero,
   output logic              resync_done
);

   localparam int unsigned GOOD_W = $clog2(RESYNC_FRAMES + 1);
   localparam int unsigned BAD_W  = $clog2(BCK_LIMIT + 2);
   localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(RESYNC_FRAMES - 1);
   localparam logic [BAD_W-1:0]  BAD_LAST  = BAD_W'(BCK_LIMIT);

   logic              err_q, zero_q, done_q;
   logic [CNT_W-1:0]  ref_q;
   logic [GOOD_W-1:0] good_q;
   logic [BAD_W-1:0]  bad_q;

   logic sck_ok, bck_ok, near_ref, overrun, drift_err, bck_err, fail;
   logic cand_good, relock;

   always_comb begin
      sck_ok    = sck_ratio_ok(32'(per_sck), TOL);
      bck_ok    = bck_ratio_ok(32'(per_bck), multi_slot);
      near_ref  = abs_diff(32'(per_sck), 32'(ref_q)) <= TOL;
      overrun   = !err_q && !lr_rise && (32'(elapsed) > 32'(ref_q) + TOL);
      drift_err = !err_q && per_done && !near_ref;
      bck_err   = !err_q && per_done && !bck_ok && (bad_q == BAD_LAST);
      fail      = overrun | drift_err | bck_err;
      cand_good = per_done && sck_ok && bck_ok && (good_q == '0 || near_ref);
      relock    = err_q && cand_good && (good_q == GOOD_LAST);
   end

   assign restart = overrun;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q  <= 1'b1;
         ref_q  <= '0;
         good_q <= '0;
         bad_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= relock;
         if (fail) begin
            err_q  <= 1'b1;
            good_q <= '0;
            bad_q  <= '0;
         end else if (err_q) begin
            if (per_done) begin
               if (cand_good) begin
                  ref_q <= per_sck;
                  if (relock) begin
                     err_q  <= 1'b0;
                     good_q <= '0;
                     bad_q  <= '0;
                  end else begin
                     good_q <= good_q + 1'b1;
                  end
               end else begin
                  good_q <= '0;
               end
            end
         end else if (per_done) begin
            bad_q <= bck_ok ? '0 : bad_q + 1'b1;
         end
      end
   end

   // separate register for the data-path mute, same set/clear events
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      zero_q <= 1'b1;
      else if (fail)   zero_q <= 1'b1;
      else if (relock) zero_q <= 1'b0;
   end

   assign clk_err     = err_q;
   assign force_zero  = zero_q;
   assign resync_done = done_q;

   a_r4_zero_tracks_err: assert property (@(posedge clk) disable iff (!rst_n)
      force_zero == clk_err);

   a_r8_pulse_only_on_lock: assert property (@(posedge clk) disable iff (!rst_n)
      resync_done |-> (!clk_err && $past(clk_err)));

   a_r2_lock_gives_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clk_err) |-> resync_done);

   a_r10_overrun_bound: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_err |-> (32'(elapsed) <= 32'(ref_q) + TOL + 1));

   a_r5_bad_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_err |-> (bad_q <= BAD_LAST));

endmodule

// File: rtl/acm_clock_monitor.sv
module acm_clock_monitor #(
   parameter int unsigned CNT_W         = 13,
   parameter int unsigned BCNT_W        = 10,
   parameter int unsigned TOL           = 5,
   parameter int unsigned RESYNC_FRAMES = 2,
   parameter int unsigned BCK_LIMIT     = 4,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter bit          TDM_SUPPORT   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bclk_in,
   input  logic lrck_in,
   input  logic tdm_mode,
   output logic clk_err,
   output logic force_zero,
   output logic resync_done
);

   localparam int unsigned MAX_SCK = 3072 + TOL + 1;

   if ((1 << CNT_W) <= MAX_SCK) begin : g_bad_cnt_w
      $error("acm_clock_monitor: CNT_W too narrow for the largest ratio");
   end
   if ((1 << BCNT_W) <= 257) begin : g_bad_bcnt_w
      $error("acm_clock_monitor: BCNT_W too narrow for 256 bit clocks");
   end
   if (TOL < 1 || RESYNC_FRAMES < 1) begin : g_bad_cfg
      $error("acm_clock_monitor: TOL and RESYNC_FRAMES must be non-zero");
   end

   logic [1:0]        rise;
   logic              multi_slot;
   logic              per_done, restart;
   logic [CNT_W-1:0]  per_sck, elapsed;
   logic [BCNT_W-1:0] per_bck;

   if (TDM_SUPPORT) begin : g_tdm
      assign multi_slot = tdm_mode;
   end else begin : g_no_tdm
      assign multi_slot = 1'b0;
   end

   acm_edge_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({lrck_in, bclk_in}),
      .rise (rise)
   );

   acm_period_counter #(.CNT_W(CNT_W), .BCNT_W(BCNT_W)) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .lr_rise (rise[1]),
      .bk_rise (rise[0]),
      .restart (restart),
      .per_done(per_done),
      .per_sck (per_sck),
      .per_bck (per_bck),
      .elapsed (elapsed)
   );

   acm_lock_ctrl #(
      .CNT_W(CNT_W), .BCNT_W(BCNT_W), .TOL(TOL),
      .RESYNC_FRAMES(RESYNC_FRAMES), .BCK_LIMIT(BCK_LIMIT)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .lr_rise    (rise[1]),
      .per_done   (per_done),
      .per_sck    (per_sck),
      .per_bck    (per_bck),
      .elapsed    (elapsed),
      .multi_slot (multi_slot),
      .restart    (restart),
      .clk_err    (clk_err),
      .force_zero (force_zero),
      .resync_done(resync_done)
   );

endmodule

// File: tb/acm_clock_monitor_tb.sv
module acm_clock_monitor_tb;

   localparam time CLK_PERIOD = 10ns;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bclk_in = 1'b0;
   logic lrck_in = 1'b0;
   logic tdm_mode = 1'b0;
   logic clk_err, force_zero, resync_done;

   int checks = 0;
   int errors = 0;
   int pulses = 0;
   bit finished = 0;

   typedef struct {
      string req;
      logic  err;
      int    rsd;
   } exp_t;
   exp_t sb_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   acm_clock_monitor u_dut (
      .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .lrck_in(lrck_in),
      .tdm_mode(tdm_mode), .clk_err(clk_err), .force_zero(force_zero),
      .resync_done(resync_done)
   );

   task automatic check(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // monitor: count pulses, pop and compare expectations away from the edge
   always @(negedge clk) begin
      if (rst_n && resync_done) pulses++;
      while (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         check(e.req, "clk_err", int'(clk_err), int'(e.err));
         check("R4", "force_zero", int'(force_zero), int'(e.err));
         check("R8", "resync pulses", pulses, e.rsd);
      end
   end

   task automatic expect_state(string req, logic err, int rsd);
      exp_t e;
      e.req = req; e.err = err; e.rsd = rsd;
      sb_q.push_back(e);
      @(negedge clk);
   endtask

   // frames of n_sck system clocks with n_bck bit clocks; adj pads (+) or trims (-)
   task automatic run_frames(int n, int n_sck, int n_bck, int adj);
      int half;
      half = n_sck / (2 * n_bck);
      for (int f = 0; f < n; f++) begin
         for (int i = 0; i < n_sck + adj; i++) begin
            @(negedge clk);
            if (i < n_sck) begin
               lrck_in = (i < n_sck / 2);
               bclk_in = ((i / half) % 2) == 1;
            end else begin
               lrck_in = 1'b0;
               bclk_in = 1'b0;
            end
         end
      end
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         lrck_in = 1'b0;
         bclk_in = 1'b0;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", "clk_err", int'(clk_err), 1);
      check("R1", "force_zero", int'(force_zero), 1);
      check("R1", "resync_done", int'(resync_done), 0);
      rst_n = 1'b1;
      @(negedge clk);

      run_frames(4, 256, 64, 0);
      expect_state("R2", 1'b0, 1);                 // R2: lock after two valid periods

      run_frames(1, 256, 64, 5);
      run_frames(1, 256, 64, 0);
      expect_state("R3", 1'b0, 1);                 // R3: +5 cycles tolerated

      run_frames(1, 256, 64, 6);
      run_frames(1, 256, 64, 0);
      expect_state("R3", 1'b1, 1);                 // R3: +6 cycles is an error

      run_frames(4, 256, 64, 0);
      expect_state("R2", 1'b0, 2);

      run_frames(4, 256, 16, 0);
      run_frames(1, 256, 64, 0);
      expect_state("R5", 1'b0, 2);                 // R5: four bad periods tolerated

      run_frames(1, 256, 64, 0);
      run_frames(5, 256, 16, 0);
      run_frames(1, 256, 64, 0);
      expect_state("R5", 1'b1, 2);                 // R5: fifth bad period is an error

      run_frames(4, 256, 64, 0);
      expect_state("R2", 1'b0, 3);

      // same edge: fifth bad bit-clock period and a 6-cycle short period
      run_frames(4, 256, 16, 0);
      run_frames(1, 256, 16, -6);
      run_frames(1, 256, 64, 0);
      expect_state("R5", 1'b1, 3);

      run_frames(4, 256, 64, 0);
      expect_state("R2", 1'b0, 4);

      idle(400);
      expect_state("R10", 1'b1, 4);                // R10: stopped word clock

      run_frames(6, 320, 32, 0);
      expect_state("R7", 1'b1, 4);                 // R7: 320 is not a supported ratio

      run_frames(5, 192, 48, 0);
      expect_state("R7", 1'b0, 5);                 // R7/R6: 192 with 48 bit clocks

      run_frames(3, 192, 48, 0);
      expect_state("R9", 1'b0, 5);                 // R9: new reference learned

      tdm_mode = 1'b1;
      run_frames(5, 512, 128, 0);
      expect_state("R6", 1'b0, 6);                 // R6: 128 allowed in multi-slot mode

      tdm_mode = 1'b0;
      run_frames(6, 512, 128, 0);
      expect_state("R6", 1'b1, 6);                 // R6: 128 rejected in two-slot mode

      repeat (2) @(negedge clk);
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule